// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen architectural general registers of a small processor core. A 5-bit operating mode selects which physical copy of some registers is visible. One privileged bank, used for fast interrupts, has its own copies of registers 8 to 14. Four other privileged banks have their own copies of registers 13 and 14 only: normal interrupt, supervisor, abort and undefined. Registers 0 to 7 and register 15 are one set shared by every mode. Any mode encoding the core does not define resolves to a scratch bank whose registers 8 to 14 start at zero.

The datapath reads two registers and writes one each cycle through architectural indices 0 to 15, always as seen from the current mode. A separate side port names a mode of its own, so context-switch or debug logic can read or write another mode's copy without changing modes. A mode change is requested with a one-cycle strobe and takes effect at the next clock edge.

Top module: `rfp_banked_regfile`

## Requirements
- R1: After reset the current mode is 19 (supervisor) and every register, in every bank, reads zero.
- R2: When `mode_we` is high at a clock edge, `mode_q` takes `mode_in` at that edge. Reads in the strobe cycle still use the old mapping, and reads from the next cycle use the new one. Without the strobe the mode holds.
- R3: Registers 0–7 and 15 are the same storage in every mode.
- R4: Modes 1 and 17 (fast interrupt) see private copies of registers 8–14.
- R5: Modes 2/18 (normal interrupt), 3/19 (supervisor), 23 (abort) and 27 (undefined) each see private registers 13 and 14. Registers 8–12 in these modes are the user copies.
- R6: Mode 31 (system) uses the user copies of registers 8–14, the same ones seen by modes 0 and 16.
- R7: Every other mode encoding selects the scratch bank. Registers 8–14 read zero right after the scratch bank is entered, and anything written there is lost once a mode change leaves that bank.
- R8: A mode change between two encodings of the same bank keeps every register value.
- R9: The side port reads and writes register `side_idx` as seen from `side_mode`. When `side_mode` resolves to the current bank it reaches the live registers.
- R10: If the main write port and the side port write the same physical register in one cycle, the main port's data is kept.
- R11: A side-port write to registers 8–14 of the scratch bank is dropped while the current mode is not in the scratch bank, and those registers still read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode-update strobe |
| mode_in | input | 5 | New mode value |
| mode_q | output | 5 | Current mode |
| ra_idx | input | 4 | Read port A register index |
| ra_data | output | DATA_W | Read port A data (combinational) |
| rb_idx | input | 4 | Read port B register index |
| rb_data | output | DATA_W | Read port B data (combinational) |
| wr_en | input | 1 | Main write enable |
| wr_idx | input | 4 | Main write register index |
| wr_data | input | DATA_W | Main write data |
| side_mode | input | 5 | Mode through which the side port looks |
| side_idx | input | 4 | Side port register index |
| side_we | input | 1 | Side port write enable |
| side_wdata | input | DATA_W | Side port write data |
| side_rdata | output | DATA_W | Side port read data (combinational) |

## Verification
A wrong bank choice shows on the read ports in the first cycle after the faulty mode change, as a value that belongs to a neighbouring bank. The tests therefore give each bank's copies distinct values and read them back across many mode switches. Storage that is not cleared on entry to the scratch bank, or not lost on exit, shows as a non-zero read there one cycle after the switch. Port-priority or dropped-write faults show on the following read of the affected register, so the tests read every written register back before anything else touches it.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
  localparam int IDX_W    = 4;
  localparam int MODE_W   = 5;
  localparam int NUM_PHYS = 38;
  localparam int PHYS_W   = $clog2(NUM_PHYS);
  localparam int NUM_LOC  = 4;

  // physical slot layout
  localparam int SLOT_PC  = 8;
  localparam int SLOT_USR = 9;
  localparam int SLOT_FIQ = 16;
  localparam int SLOT_DUM = 23;
  localparam int DUM_CNT  = 7;
  localparam int SLOT_IRQ = 30;
  localparam int SLOT_SVC = 32;
  localparam int SLOT_ABT = 34;
  localparam int SLOT_UND = 36;

  localparam logic [MODE_W-1:0] MODE_RST = 5'd19;

  typedef enum logic [2:0] {
    BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND, BK_DUM
  } bank_e;

  function automatic bank_e mode_bank(input logic [MODE_W-1:0] m);
    bank_e b;
    case (m)
      5'd0, 5'd16, 5'd31: b = BK_USR;
      5'd1, 5'd17:        b = BK_FIQ;
      5'd2, 5'd18:        b = BK_IRQ;
      5'd3, 5'd19:        b = BK_SVC;
      5'd23:              b = BK_ABT;
      5'd27:              b = BK_UND;
      default:            b = BK_DUM;
    endcase
    return b;
  endfunction

  function automatic logic is_shared(input logic [IDX_W-1:0] r);
    return (r < 4'd8) || (r == 4'd15);
  endfunction

  function automatic logic [PHYS_W-1:0] phys_slot(input bank_e b,
                                                  input logic [IDX_W-1:0] r);
    logic [PHYS_W-1:0] off;
    logic [PHYS_W-1:0] hi;
    logic [PHYS_W-1:0] s;
    off = PHYS_W'(r) - PHYS_W'(8);
    hi  = PHYS_W'(r) - PHYS_W'(13);
    if (r == 4'd15)      s = PHYS_W'(SLOT_PC);
    else if (r < 4'd8)   s = PHYS_W'(r);
    else begin
      case (b)
        BK_FIQ:  s = PHYS_W'(SLOT_FIQ) + off;
        BK_DUM:  s = PHYS_W'(SLOT_DUM) + off;
        default: s = PHYS_W'(SLOT_USR) + off;
      endcase
      if (r >= 4'd13) begin
        case (b)
          BK_IRQ:  s = PHYS_W'(SLOT_IRQ) + hi;
          BK_SVC:  s = PHYS_W'(SLOT_SVC) + hi;
          BK_ABT:  s = PHYS_W'(SLOT_ABT) + hi;
          BK_UND:  s = PHYS_W'(SLOT_UND) + hi;
          default: ;
        endcase
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/rfp_mode_ctl.sv
module rfp_mode_ctl
  import rfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_in,
  output logic [MODE_W-1:0] mode_q,
  output bank_e             cur_bank,
  output logic              bank_switch,
  output logic              dummy_clear
);
  bank_e new_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_RST;
    else if (mode_we) mode_q <= mode_in;
  end

  assign cur_bank    = mode_bank(mode_q);
  assign new_bank    = mode_bank(mode_in);
  assign bank_switch = mode_we && (new_bank != cur_bank);
  assign dummy_clear = bank_switch && ((cur_bank == BK_DUM) || (new_bank == BK_DUM));
endmodule

// File: rtl/rfp_locate.sv
module rfp_locate
  import rfp_pkg::*;
(
  input  bank_e             bank,
  input  logic [IDX_W-1:0]  idx,
  output logic [PHYS_W-1:0] slot
);
  assign slot = phys_slot(bank, idx);
endmodule

// File: rtl/rfp_store.sv
module rfp_store
  import rfp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [PHYS_W-1:0]                wr_slot,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             s_en,
  input  logic [PHYS_W-1:0]                s_slot,
  input  logic [DATA_W-1:0]                s_data,
  input  logic                             clr_en,
  output logic [NUM_PHYS-1:0][DATA_W-1:0]  q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      for (int i = 0; i < NUM_PHYS; i++) begin
        if (clr_en && (i >= SLOT_DUM) && (i < SLOT_DUM + DUM_CNT))
          q[i] <= '0;
        else if (wr_en && (wr_slot == PHYS_W'(i)))
          q[i] <= wr_data;
        else if (s_en && (s_slot == PHYS_W'(i)))
          q[i] <= s_data;
      end
    end
  end
endmodule

// File: rtl/rfp_banked_regfile.sv
module rfp_banked_regfile
  import rfp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [4:0]        mode_in,
  output logic [4:0]        mode_q,
  input  logic [3:0]        ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [3:0]        rb_idx,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [4:0]        side_mode,
  input  logic [3:0]        side_idx,
  input  logic              side_we,
  input  logic [DATA_W-1:0] side_wdata,
  output logic [DATA_W-1:0] side_rdata
);
  bank_e cur_bank;
  bank_e side_bank;
  logic  bank_switch;
  logic  dummy_clear;
  logic  side_blocked;
  logic  side_wr_ok;

  bank_e             loc_bank [NUM_LOC];
  logic [IDX_W-1:0]  loc_idx  [NUM_LOC];
  logic [PHYS_W-1:0] loc_slot [NUM_LOC];
  logic [NUM_PHYS-1:0][DATA_W-1:0] phys_q;

  rfp_mode_ctl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_we     (mode_we),
    .mode_in     (mode_in),
    .mode_q      (mode_q),
    .cur_bank    (cur_bank),
    .bank_switch (bank_switch),
    .dummy_clear (dummy_clear)
  );

  assign side_bank = mode_bank(side_mode);

  // port 0/1: reads, port 2: main write, port 3: side access
  assign loc_bank[0] = cur_bank;  assign loc_idx[0] = ra_idx;
  assign loc_bank[1] = cur_bank;  assign loc_idx[1] = rb_idx;
  assign loc_bank[2] = cur_bank;  assign loc_idx[2] = wr_idx;
  assign loc_bank[3] = side_bank; assign loc_idx[3] = side_idx;

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
    rfp_locate u_loc (
      .bank (loc_bank[g]),
      .idx  (loc_idx[g]),
      .slot (loc_slot[g])
    );
  end

  // scratch bank storage is only reachable while it is the live bank
  assign side_blocked = (side_bank == BK_DUM) && (cur_bank != BK_DUM) && !is_shared(side_idx);
  assign side_wr_ok   = side_we && !side_blocked;

  rfp_store #(.DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_slot (loc_slot[2]),
    .wr_data (wr_data),
    .s_en    (side_wr_ok),
    .s_slot  (loc_slot[3]),
    .s_data  (side_wdata),
    .clr_en  (dummy_clear),
    .q       (phys_q)
  );

  assign ra_data    = phys_q[loc_slot[0]];
  assign rb_data    = phys_q[loc_slot[1]];
  assign side_rdata = phys_q[loc_slot[3]];
endmodule

// File: rtl/rfp_checker.sv
module rfp_checker
  import rfp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_we,
  input logic [4:0]        mode_in,
  input logic [4:0]        mode_q,
  input logic [3:0]        ra_idx,
  input logic [DATA_W-1:0] ra_data,
  input logic [3:0]        side_idx,
  input logic [DATA_W-1:0] side_rdata,
  input bank_e             cur_bank,
  input bank_e             side_bank,
  input logic              bank_switch
);
  AST_RESET_SVC: assert property (@(posedge clk) !rst_n |=> (mode_q == MODE_RST)); // R1

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (mode_q == $past(mode_in))); // R2

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> $stable(mode_q)); // R2

  AST_SHARED_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    ((ra_idx == side_idx) && is_shared(ra_idx)) |-> (side_rdata == ra_data)); // R3

  AST_SIDE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((side_bank == cur_bank) && (side_idx == ra_idx)) |-> (side_rdata == ra_data)); // R9

  AST_SCRATCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bank_switch |=> ((cur_bank != BK_DUM) || is_shared(ra_idx) || (ra_data == '0))); // R7
endmodule

bind rfp_banked_regfile rfp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_we     (mode_we),
  .mode_in     (mode_in),
  .mode_q      (mode_q),
  .ra_idx      (ra_idx),
  .ra_data     (ra_data),
  .side_idx    (side_idx),
  .side_rdata  (side_rdata),
  .cur_bank    (cur_bank),
  .side_bank   (side_bank),
  .bank_switch (bank_switch)
);

// File: tb/sim_rfp_banked_regfile.sv
`timescale 1ns/1ps
module sim_rfp_banked_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [4:0]  mode_in = '0;
  logic [4:0]  mode_q;
  logic [3:0]  ra_idx = '0;
  logic [31:0] ra_data;
  logic [3:0]  rb_idx = '0;
  logic [31:0] rb_data;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  side_mode = '0;
  logic [3:0]  side_idx = '0;
  logic        side_we = 1'b0;
  logic [31:0] side_wdata = '0;
  logic [31:0] side_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  rfp_banked_regfile u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setmode(input logic [4:0] m);
    @(negedge clk); mode_in = m; mode_we = 1'b1;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic wr(input logic [3:0] i, input logic [31:0] d);
    @(negedge clk); wr_idx = i; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [3:0] i, input logic [31:0] exp);
    @(negedge clk); ra_idx = i; #1;
    chk(req, ra_data, exp);
  endtask

  task automatic side_wr(input logic [4:0] m, input logic [3:0] i, input logic [31:0] d);
    @(negedge clk); side_mode = m; side_idx = i; side_wdata = d; side_we = 1'b1;
    @(negedge clk); side_we = 1'b0;
  endtask

  task automatic side_chk(input string req, input logic [4:0] m, input logic [3:0] i,
                          input logic [31:0] exp);
    @(negedge clk); side_mode = m; side_idx = i; #1;
    chk(req, side_rdata, exp);
  endtask

  task automatic t_reset;
    chk("R1 mode", {27'd0, mode_q}, 32'd19);
    for (int i = 0; i < 16; i++) rdchk("R1 reg", 4'(i), 32'h0);
    side_chk("R1 fiq r12", 5'd17, 4'd12, 32'h0);
  endtask

  task automatic t_shared;
    wr(4'd3, 32'hA3);
    wr(4'd15, 32'hF15);
    setmode(5'd17);
    rdchk("R3 r3", 4'd3, 32'hA3);
    rdchk("R3 r15", 4'd15, 32'hF15);
    @(negedge clk); rb_idx = 4'd3; #1;
    chk("R3 rb r3", rb_data, 32'hA3);
    setmode(5'd19);
  endtask

  task automatic t_fiq;
    setmode(5'd16);
    for (int i = 8; i < 15; i++) wr(4'(i), 32'h100 + i);
    setmode(5'd17);
    rdchk("R4 fiq r8", 4'd8, 32'h0);
    rdchk("R4 fiq r14", 4'd14, 32'h0);
    wr(4'd10, 32'hF10);
    rdchk("R4 fiq r10", 4'd10, 32'hF10);
    setmode(5'd16);
    rdchk("R4 usr r10", 4'd10, 32'h10A);
  endtask

  task automatic t_priv;
    setmode(5'd18);
    rdchk("R5 irq r8", 4'd8, 32'h108);
    rdchk("R5 irq r12", 4'd12, 32'h10C);
    rdchk("R5 irq r13", 4'd13, 32'h0);
    wr(4'd13, 32'h213);
    setmode(5'd19);
    rdchk("R5 svc r13", 4'd13, 32'h0);
    setmode(5'd23);
    wr(4'd14, 32'h714);
    setmode(5'd27);
    rdchk("R5 und r14", 4'd14, 32'h0);
    setmode(5'd2);
    rdchk("R5 irq r13 back", 4'd13, 32'h213);
    side_chk("R5 abt r14", 5'd23, 4'd14, 32'h714);
  endtask

  task automatic t_sys;
    setmode(5'd31);
    rdchk("R6 sys r13", 4'd13, 32'h10D);
    wr(4'd12, 32'h3C);
    setmode(5'd0);
    rdchk("R8 usr0 r12", 4'd12, 32'h3C);
    setmode(5'd16);
    rdchk("R8 usr16 r12", 4'd12, 32'h3C);
  endtask

  task automatic t_dummy;
    setmode(5'd5);
    rdchk("R7 dum r8", 4'd8, 32'h0);
    rdchk("R7 dum r14", 4'd14, 32'h0);
    rdchk("R7 dum r3", 4'd3, 32'hA3);
    wr(4'd9, 32'h99);
    rdchk("R7 dum r9 wr", 4'd9, 32'h99);
    setmode(5'd16);
    rdchk("R7 usr r9", 4'd9, 32'h109);
    setmode(5'd5);
    rdchk("R7 dum r9 lost", 4'd9, 32'h0);
    setmode(5'd16);
  endtask

  task automatic t_same_cycle;
    @(negedge clk); ra_idx = 4'd8; mode_in = 5'd17; mode_we = 1'b1; #1;
    chk("R2 old map", ra_data, 32'h108);
    @(negedge clk); mode_we = 1'b0; #1;
    chk("R2 new map", ra_data, 32'h0);
    chk("R2 mode", {27'd0, mode_q}, 32'd17);
    setmode(5'd16);
  endtask

  task automatic t_side;
    side_chk("R9 side fiq r10", 5'd17, 4'd10, 32'hF10);
    side_wr(5'd19, 4'd14, 32'h5E);
    side_chk("R9 side svc r14", 5'd19, 4'd14, 32'h5E);
    rdchk("R9 usr r14 kept", 4'd14, 32'h10E);
    setmode(5'd19);
    rdchk("R9 svc r14", 4'd14, 32'h5E);
    side_wr(5'd19, 4'd13, 32'h31);
    rdchk("R9 live r13", 4'd13, 32'h31);
    side_chk("R9 side usr r13", 5'd16, 4'd13, 32'h10D);
    setmode(5'd16);
  endtask

  task automatic t_conflict;
    @(negedge clk);
    wr_idx = 4'd9; wr_data = 32'hAAAA; wr_en = 1'b1;
    side_mode = 5'd0; side_idx = 4'd9; side_wdata = 32'hBBBB; side_we = 1'b1;
    @(negedge clk); wr_en = 1'b0; side_we = 1'b0;
    rdchk("R10 main wins", 4'd9, 32'hAAAA);
  endtask

  task automatic t_dummy_side;
    side_wr(5'd9, 4'd10, 32'h77);
    side_chk("R11 dum side r10", 5'd9, 4'd10, 32'h0);
    rdchk("R11 usr r10", 4'd10, 32'h10A);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_shared();
    t_fiq();
    t_priv();
    t_sys();
    t_dummy();
    t_same_cycle();
    t_side();
    t_conflict();
    t_dummy_side();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule